// File: doc/BRIEF.md
# Delayed-Branch Fetch and Execute Pipeline

This block is a compact in-order processor front end. One stage fetches a fixed 32-bit instruction word from an instruction memory each cycle. A second stage decodes and executes it. Register-to-register instructions finish in that execute stage. Loads and stores take one more cycle in a memory stage, which drives a simple data memory port. The data memory answers a read in the same cycle as the request.

Branches are delayed. The word fetched while a branch executes is the delay slot, and it always executes, whether or not the branch is taken. Only after that fetch has gone out is the program counter loaded with the branch target, so no fetched instruction is ever discarded. The only hazard logic is an interlock. When the instruction in execute reads the destination of a load that is still in its memory stage, the pipeline holds for one cycle.

Top module: `dbp_core`

## Requirements
- R1: In the cycle after a synchronous active-low reset, the fetch address is 0, no data memory access is requested, and the execute and memory stages hold no-ops.
- R2: Bits [31:30] select the class: 00 ALU, 01 load, 10 store, 11 branch. An ALU word has its destination in [29:27], source A in [26:24], source B in [23:21] and the operation in [20:19]: 00 add, 01 subtract (A minus B), 10 AND, 11 XOR.
- R3: An ALU result is written at the end of its execute cycle, so the very next instruction can read it without a stall.
- R4: A load (destination [29:27], base [26:24], zero-extended offset [18:0]) computes base plus offset in execute. In the following cycle it raises the read strobe with that address and writes the returned word to its destination.
- R5: A store (base [26:24], data register [23:21], offset [18:0]) raises the write strobe, with address base plus offset and the data register's value, in the cycle after its execute cycle.
- R6: Register 0 always reads as zero. Writes to register 0 have no effect.
- R7: When the instruction in execute reads the destination of a load that is in its memory stage, the fetch address and the executing instruction hold for exactly one cycle, and a bubble enters the memory stage. The registers read are source A for every class, and source B as well for ALU and store.
- R8: When a branch is taken, the next fetch is the word after the branch (the delay slot), which executes. The fetch after that is the target held in bits [18:0].
- R9: The branch condition is in [29:28], tested on the register in [26:24]: 00 always, 01 if zero, 10 if non-zero, 11 never.
- R10: When there is neither a stall nor a taken branch, the fetch address advances by one word each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | AW | Word address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | AW | Data memory word address |
| dmem_re | output | 1 | Load read strobe |
| dmem_rdata | input | DW | Read data for dmem_addr, valid in the same cycle |
| dmem_we | output | 1 | Store write strobe |
| dmem_wdata | output | DW | Store data |

## Verification
The assertions assume the instruction memory and data memory answer combinationally in the cycle the address is shown, and that reset is held for at least one clock edge. The bench models both memories as combinational arrays and holds reset for three edges. The program runs each instruction class and each branch condition. It also covers a branch that is stalled by a load it depends on, a store followed by a load of the same word, and an ALU write to register 0. It ends in a self-branch loop, so the fetch stream stays defined for the rest of the run.

// File: rtl/dbp_pkg.sv
// Shared types for the delayed-branch pipeline.
// Assumes fixed 32-bit words with fields at fixed positions (see decode).
package dbp_pkg;
    localparam int ILEN = 32;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);
    localparam int IMMW = 19;

    typedef enum logic [1:0] {CL_ALU = 2'b00, CL_LOAD = 2'b01, CL_STORE = 2'b10, CL_BRANCH = 2'b11} iclass_e;
    typedef enum logic [1:0] {OP_ADD = 2'b00, OP_SUB = 2'b01, OP_AND = 2'b10, OP_XOR = 2'b11} aluop_e;
    typedef enum logic [1:0] {BR_ALWAYS = 2'b00, BR_ZERO = 2'b01, BR_NONZERO = 2'b10, BR_NEVER = 2'b11} brcond_e;

    typedef struct packed {
        iclass_e         cls;
        logic [RIDX-1:0] dst;
        logic [RIDX-1:0] src_a;
        logic [RIDX-1:0] src_b;
        aluop_e          op;
        brcond_e         cond;
        logic [IMMW-1:0] imm;
    } dec_t;

    // Split a word into its fields; every class uses the same positions.
    function automatic dec_t decode(input logic [ILEN-1:0] w);
        dec_t d;
        d.cls   = iclass_e'(w[31:30]);
        d.dst   = w[29:27];
        d.cond  = brcond_e'(w[29:28]);
        d.src_a = w[26:24];
        d.src_b = w[23:21];
        d.op    = aluop_e'(w[20:19]);
        d.imm   = w[18:0];
        return d;
    endfunction
endpackage

// File: rtl/dbp_fetch.sv
// Program counter for the fetch stage.
// Assumes hold and redirect come from the execute stage in the same cycle;
// hold wins over redirect, so a stalled branch cannot move the PC.
module dbp_fetch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    // Choose the next fetch address: hold, branch target, or next word.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= '0;
        else if (hold)     pc <= pc;
        else if (redirect) pc <= target;
        else               pc <= pc + AW'(1);
    end

    // R10
    seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !redirect) |=> (pc == $past(pc) + AW'(1)));
    // R8
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !hold) |=> (pc == $past(target)));
endmodule

// File: rtl/dbp_regfile.sv
// Architectural register file: two combinational reads and two writes.
// The execute-stage write takes priority over the memory-stage write,
// because it belongs to the younger instruction. Register 0 is constant zero.
module dbp_regfile
    import dbp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] ra_a,
    input  logic [RIDX-1:0] ra_b,
    output logic [DW-1:0]   rd_a,
    output logic [DW-1:0]   rd_b,
    input  logic            we_ex,
    input  logic [RIDX-1:0] wa_ex,
    input  logic [DW-1:0]   wd_ex,
    input  logic            we_mem,
    input  logic [RIDX-1:0] wa_mem,
    input  logic [DW-1:0]   wd_mem
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        if (g == 0) begin : g_zero
            assign q = '0;
        end else begin : g_live
            // Update one register, execute-stage write first.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 q <= '0;
                else if (we_ex  && wa_ex  == RIDX'(g))      q <= wd_ex;
                else if (we_mem && wa_mem == RIDX'(g))      q <= wd_mem;
            end
        end
        assign regs[g] = q;
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
endmodule

// File: rtl/dbp_exec.sv
// Combinational execute stage: ALU result, load/store address and branch decision.
// Assumes operands are already read from the register file.
module dbp_exec
    import dbp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  aluop_e          op,
    input  brcond_e         cond,
    input  logic [IMMW-1:0] imm,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic [DW-1:0]   alu_res,
    output logic [AW-1:0]   mem_addr,
    output logic            take
);
    // Register-to-register arithmetic and logic.
    always_comb begin
        unique case (op)
            OP_ADD:  alu_res = opa + opb;
            OP_SUB:  alu_res = opa - opb;
            OP_AND:  alu_res = opa & opb;
            default: alu_res = opa ^ opb;
        endcase
    end

    assign mem_addr = AW'(opa + DW'(imm));

    // Branch condition on source A.
    always_comb begin
        unique case (cond)
            BR_ALWAYS:  take = 1'b1;
            BR_ZERO:    take = (opa == '0);
            BR_NONZERO: take = (opa != '0);
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbp_core.sv
// Delayed-branch pipeline: fetch, execute, and a memory stage used only by
// loads and stores. The word fetched during a branch always executes.
// Assumes both memories return data in the cycle the address is shown.
// The only hazard logic is a one-cycle interlock on a load result.
module dbp_core
    import dbp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   imem_addr,
    input  logic [ILEN-1:0] imem_rdata,
    output logic [AW-1:0]   dmem_addr,
    output logic            dmem_re,
    input  logic [DW-1:0]   dmem_rdata,
    output logic            dmem_we,
    output logic [DW-1:0]   dmem_wdata
);
    logic [AW-1:0]   pc;
    logic [ILEN-1:0] ex_ir;
    dec_t            ex_d;
    logic [DW-1:0]   opa, opb, alu_res;
    logic [AW-1:0]   ea;
    logic            take, uses_b, stall, redirect;
    logic            mem_ld, mem_st;
    logic [RIDX-1:0] mem_rd;
    logic [AW-1:0]   mem_ea;
    logic [DW-1:0]   mem_wd;

    assign ex_d   = decode(ex_ir);
    assign uses_b = (ex_d.cls == CL_ALU) || (ex_d.cls == CL_STORE);

    // Interlock: the executing word needs a load result not yet written.
    assign stall = mem_ld && (mem_rd != '0) &&
                   ((mem_rd == ex_d.src_a) || (uses_b && (mem_rd == ex_d.src_b)));
    assign redirect = (ex_d.cls == CL_BRANCH) && take && !stall;

    dbp_fetch #(.AW(AW)) i_fetch (
        .clk(clk), .rst_n(rst_n), .hold(stall), .redirect(redirect),
        .target(AW'(ex_d.imm)), .pc(pc)
    );

    dbp_regfile #(.DW(DW)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_a(ex_d.src_a), .ra_b(ex_d.src_b), .rd_a(opa), .rd_b(opb),
        .we_ex(!stall && ex_d.cls == CL_ALU), .wa_ex(ex_d.dst), .wd_ex(alu_res),
        .we_mem(mem_ld), .wa_mem(mem_rd), .wd_mem(dmem_rdata)
    );

    dbp_exec #(.AW(AW), .DW(DW)) i_exec (
        .op(ex_d.op), .cond(ex_d.cond), .imm(ex_d.imm), .opa(opa), .opb(opb),
        .alu_res(alu_res), .mem_addr(ea), .take(take)
    );

    // Fetch-to-execute register; keeps its word during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n)      ex_ir <= '0;
        else if (!stall) ex_ir <= imem_rdata;
    end

    // Execute-to-memory register; a stall inserts a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ld <= 1'b0;
            mem_st <= 1'b0;
            mem_rd <= '0;
            mem_ea <= '0;
            mem_wd <= '0;
        end else begin
            mem_ld <= !stall && (ex_d.cls == CL_LOAD);
            mem_st <= !stall && (ex_d.cls == CL_STORE);
            mem_rd <= ex_d.dst;
            mem_ea <= ea;
            mem_wd <= opb;
        end
    end

    assign imem_addr  = pc;
    assign dmem_addr  = mem_ea;
    assign dmem_re    = mem_ld;
    assign dmem_we    = mem_st;
    assign dmem_wdata = mem_wd;

    // R7
    stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (imem_addr == $past(imem_addr)));
    // R4
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_we, dmem_re}));
    // R5
    store_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && ex_d.cls == CL_STORE) |=> (dmem_we && !dmem_re));
endmodule

// File: tb/test_dbp_core.sv
`timescale 1ns/1ps
module test_dbp_core;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int RUN = 70;
    localparam int WDOG = 200000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] imem_addr, dmem_addr;
    logic [31:0]   imem_rdata;
    logic [DW-1:0] dmem_rdata, dmem_wdata;
    logic          dmem_re, dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          fcount [64];
    int          ntests = 0;
    int          nfail = 0;

    always #10 clk = ~clk;

    assign imem_rdata = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[5:0]];

    dbp_core #(.AW(AW), .DW(DW)) i_dbp_core (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_wdata(dmem_wdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] alu(input int op, input int rd, input int ra, input int rb);
        return {2'b00, 3'(rd), 3'(ra), 3'(rb), 2'(op), 19'b0};
    endfunction
    function automatic logic [31:0] ld(input int rd, input int ra, input int off);
        return {2'b01, 3'(rd), 3'(ra), 5'b0, 19'(off)};
    endfunction
    function automatic logic [31:0] st(input int rb, input int ra, input int off);
        return {2'b10, 3'b0, 3'(ra), 3'(rb), 2'b0, 19'(off)};
    endfunction
    function automatic logic [31:0] br(input int cond, input int ra, input int tgt);
        return {2'b11, 2'(cond), 1'b0, 3'(ra), 5'b0, 19'(tgt)};
    endfunction

    // Test program
    initial begin
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
        imem[0]  = ld(1, 0, 0);
        imem[1]  = ld(2, 0, 1);
        imem[2]  = alu(0, 3, 1, 2);     // load-use stall, r3 = 8
        imem[3]  = alu(1, 4, 1, 2);     // r4 = 2
        imem[4]  = st(3, 0, 16);
        imem[5]  = st(4, 0, 17);
        imem[6]  = br(0, 0, 9);         // always
        imem[7]  = alu(0, 5, 3, 4);     // delay slot, r5 = 10
        imem[8]  = st(1, 0, 18);        // skipped
        imem[9]  = st(5, 0, 19);
        imem[10] = br(1, 3, 13);        // if zero: not taken
        imem[11] = alu(3, 6, 3, 4);     // r6 = 10
        imem[12] = st(6, 0, 20);
        imem[13] = ld(7, 0, 2);
        imem[14] = br(2, 7, 17);        // stalled on r7, then taken
        imem[15] = alu(2, 1, 7, 2);     // delay slot, r1 = 3
        imem[16] = st(7, 0, 21);        // skipped
        imem[17] = st(1, 0, 22);
        imem[18] = ld(2, 0, 22);
        imem[19] = st(2, 0, 23);        // stall on loaded data
        imem[20] = alu(0, 0, 1, 1);     // write to r0
        imem[21] = st(0, 0, 24);
        imem[22] = br(3, 0, 0);         // never
        imem[23] = 32'h0;
        imem[24] = br(0, 0, 24);        // self loop
        imem[25] = 32'h0;
    end

    // Reference model state
    logic [AW-1:0] m_pc;
    logic [31:0]   m_ir;
    logic          m_ld, m_st;
    int            m_rd;
    logic [AW-1:0] m_ea;
    logic [31:0]   m_wd;
    logic [31:0]   rf [8];

    // Compare the ports to the model every cycle, then advance the model.
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", "fetch address in reset", 32'(imem_addr), 32'h0);
            chk("R1", "no data access in reset", {30'b0, dmem_we, dmem_re}, 32'h0);
            m_pc = '0; m_ir = '0; m_ld = 0; m_st = 0; m_rd = 0; m_ea = '0; m_wd = '0;
            for (int i = 0; i < 8; i++) rf[i] = '0;
            for (int i = 0; i < 64; i++) begin dmem[i] = '0; fcount[i] = 0; end
            dmem[0] = 32'd5; dmem[1] = 32'd3; dmem[2] = 32'h0F0F; dmem[24] = 32'h55;
        end else begin
            int cls, rd, ra, rb, op, cnd, imm;
            logic [31:0] va, vb, res, ldv;
            logic stl, tk;
            chk("R10", "fetch address", 32'(imem_addr), 32'(m_pc));
            chk("R4", "read strobe", 32'(dmem_re), 32'(m_ld));
            chk("R5", "write strobe", 32'(dmem_we), 32'(m_st));
            if (m_ld) chk("R4", "load address", 32'(dmem_addr), 32'(m_ea));
            if (m_st) begin
                chk("R5", "store address", 32'(dmem_addr), 32'(m_ea));
                chk("R5", "store data", dmem_wdata, m_wd);
            end
            fcount[imem_addr[5:0]]++;
            ldv = dmem[m_ea[5:0]];
            if (dmem_we) dmem[dmem_addr[5:0]] = dmem_wdata;

            cls = int'(m_ir[31:30]); rd = int'(m_ir[29:27]); ra = int'(m_ir[26:24]);
            rb = int'(m_ir[23:21]); op = int'(m_ir[20:19]); cnd = int'(m_ir[29:28]);
            imm = int'(m_ir[18:0]);
            va = rf[ra]; vb = rf[rb];
            stl = m_ld && m_rd != 0 && (m_rd == ra || ((cls == 0 || cls == 2) && m_rd == rb));
            if (m_ld && m_rd != 0) rf[m_rd] = ldv;
            m_ld = 0; m_st = 0; tk = 0;
            if (!stl) begin
                case (cls)
                    0: begin
                        case (op)
                            0: res = va + vb;
                            1: res = va - vb;
                            2: res = va & vb;
                            default: res = va ^ vb;
                        endcase
                        if (rd != 0) rf[rd] = res;
                    end
                    1: begin m_ld = 1; m_rd = rd; m_ea = AW'(va + 32'(imm)); end
                    2: begin m_st = 1; m_ea = AW'(va + 32'(imm)); m_wd = vb; end
                    default: tk = (cnd == 0) || (cnd == 1 && va == 0) || (cnd == 2 && va != 0);
                endcase
                m_ir = imem[m_pc[5:0]];
                m_pc = tk ? AW'(imm) : m_pc + 1'b1;
            end
        end
    end

    initial begin
        #(WDOG * 20);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (RUN) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R3", "add result stored", dmem[16], 32'd8);
        chk("R2", "subtract result stored", dmem[17], 32'd2);
        chk("R8", "word after delay slot skipped", dmem[18], 32'd0);
        chk("R8", "delay slot executed", dmem[19], 32'd10);
        chk("R9", "not-taken zero test falls through", dmem[20], 32'd10);
        chk("R9", "taken non-zero test skips", dmem[21], 32'd0);
        chk("R2", "AND result stored", dmem[22], 32'd3);
        chk("R4", "store then load same word", dmem[23], 32'd3);
        chk("R6", "register 0 stays zero", dmem[24], 32'd0);
        chk("R7", "fetch held on ALU load-use", 32'(fcount[3]), 32'd2);
        chk("R7", "fetch held on branch load-use", 32'(fcount[15]), 32'd2);
        chk("R7", "fetch held on store load-use", 32'(fcount[20]), 32'd2);
        chk("R8", "skipped word 8 never fetched", 32'(fcount[8]), 32'd0);
        chk("R8", "skipped word 16 never fetched", 32'(fcount[16]), 32'd0);
        chk("R10", "fall-through word fetched once", 32'(fcount[12]), 32'd1);
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule